// File: doc/BRIEF.md
# Closed Caption Line Serializer

This block draws the digital waveform of one caption data line for a video encoder's luma path. When the line counter reaches a programmable insertion line, in a field that the enable setting selects, the block takes over the luma level for that whole line. After a fixed delay from the line start it sends a 26-bit frame. The frame begins with seven clock run-in cycles. Three start bits follow, then two bytes. Each byte is seven data bits followed by an odd-parity bit, and it goes out least significant bit first.

Bit timing comes from the 27 MHz sample clock through a fractional phase accumulator. Each bit lasts about 53.67 clocks, so the bit rate is close to 503 kHz, and the error does not build up across the frame. Each field has its own pair of byte registers and its own status flag. The flag rises once that field's bytes have gone out, and it drops when software writes fresh bytes. If a field is sent again with no new write, the frame carries zero data with the parity bits set, which is 0x80 for both bytes.

Top module: `ccLineSerializer`

## Requirements
- R1: After reset, ccOverride is 0, ccLevel equals the blank code (default 64), and both status flags are 0.
- R2: The insertion line is ccLine+4 when palMode is 0 and ccLine+1 when palMode is 1. No other line value starts a frame.
- R3: ccEnable bit 0 enables odd fields (fieldOdd=1) and bit 1 enables even fields. When the bit for the current field is 0, the line is left untouched: ccOverride stays 0.
- R4: Bits 0 to 6 of the frame form the run-in. In each of these bit periods, ccLevel is the high code (default 176) during the first half and the blank code during the second half.
- R5: Bits 7, 8 and 9 of the frame carry the start pattern 0, 0, 1. A 1 drives the high code and a 0 drives the blank code.
- R6: Bits 10 to 17 carry the first byte and bits 18 to 25 carry the second byte. Each byte sends data bits 0 to 6 in that order, then a parity bit that makes the count of ones odd. Bit 7 of a written byte is ignored.
- R7: A field sent after reset, or sent again with no write since its last frame, carries 0x80 for both bytes: zero data and parity 1.
- R8: A field's status flag rises when the last bit of that field's frame ends. A write to that field's bytes clears the flag on the next clock.
- R9: Frame bit k (k counted from 0) is present on ccLevel from START_DLY+2 clocks after the line-start clock. Bit boundaries fall where the phase accumulator, stepping by PHASE_INC modulo 2^PHASE_W, wraps.
- R10: On the insertion line, ccOverride is 1 from 2 clocks after the line start until the next line start. Outside the frame, ccLevel holds the blank code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-clock pulse at the start of each video line |
| lineNum | input | 10 | Line number, valid with lineStart |
| fieldOdd | input | 1 | 1 for an odd field, 0 for an even field, valid with lineStart |
| palMode | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| ccEnable | input | 2 | Bit 0 enables odd fields, bit 1 enables even fields |
| ccLine | input | 5 | Programmed insertion line value |
| wrOdd | input | 1 | Write strobe for the odd-field byte pair |
| wrEven | input | 1 | Write strobe for the even-field byte pair |
| wrByte0 | input | 8 | First byte to store |
| wrByte1 | input | 8 | Second byte to store |
| ccOverride | output | 1 | High while the block owns the luma level of the line |
| ccLevel | output | 8 | Luma level code: blank or high |
| statusOdd | output | 1 | Odd-field bytes have been sent |
| statusEven | output | 1 | Even-field bytes have been sent |

## Verification
ccOverride follows a matching line start by two clocks, and a write clears the status flag one clock after the write. The level of frame bit k is due START_DLY+2 clocks after the line start, plus (k+0.5)·2^16/PHASE_INC clocks to the centre of the bit. The bench computes each of these offsets from the line-start clock and samples data bits at their centres. It samples run-in bits at the quarter and three-quarter points, so a one-clock slip at a bit edge cannot alter a result. The status flags are read near the end of the line, after the 26th bit has ended.

// File: rtl/ccPkg.sv
package ccPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic load;      // load frame shift register this cycle
    logic useNull;   // load the null byte pair
    logic fieldOdd;  // which field's bytes to load
    logic shift;     // advance frame shift register
    logic sending;   // frame in progress
    logic runIn;     // current bit is part of the run-in
    logic runHigh;   // first half of the current bit period
    logic lineOn;    // current line is the insertion line
  } ccStrobes_t;
endpackage

// File: rtl/ccCtrl.sv
module ccCtrl
  import ccPkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int SET_W      = 5,
  parameter int NTSC_OFS   = 4,
  parameter int PAL_OFS    = 1,
  parameter int PHASE_W    = 16,
  parameter int PHASE_INC  = 1221,
  parameter int START_DLY  = 270,
  parameter int FRAME_BITS = 26,
  parameter int RUNIN_BITS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              fieldOdd,
  input  logic              palMode,
  input  logic [1:0]        ccEnable,
  input  logic [SET_W-1:0]  ccLine,
  input  logic              wrOdd,
  input  logic              wrEven,
  output ccStrobes_t        strb,
  output logic              statusOdd,
  output logic              statusEven
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int DLY_W = $clog2(START_DLY + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} state_t;
  state_t state;

  logic [DLY_W-1:0]   dlyCnt;
  logic [PHASE_W-1:0] acc;
  logic [PHASE_W:0]   accSum;
  logic [IDX_W-1:0]   bitIdx;
  logic [LINE_W-1:0]  target;
  logic               curOdd, lineOn, pendOdd, pendEven;
  logic               fieldOn, hit, carry, lastBit, loadNow, doneNow;

  always_comb begin
    target  = LINE_W'(ccLine) + (palMode ? LINE_W'(PAL_OFS) : LINE_W'(NTSC_OFS));
    fieldOn = fieldOdd ? ccEnable[0] : ccEnable[1];
    hit     = lineStart && (lineNum == target) && fieldOn;
    accSum  = {1'b0, acc} + (PHASE_W+1)'(PHASE_INC);
    carry   = accSum[PHASE_W];
    lastBit = (bitIdx == IDX_W'(FRAME_BITS-1));
    loadNow = (state == S_WAIT) && (dlyCnt == DLY_W'(START_DLY-1));
    doneNow = (state == S_SEND) && carry && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      dlyCnt <= '0;
      acc    <= '0;
      bitIdx <= '0;
      curOdd <= 1'b0;
      lineOn <= 1'b0;
    end else begin
      if (lineStart) lineOn <= hit;
      unique case (state)
        S_IDLE: if (hit) begin
          state  <= S_WAIT;
          dlyCnt <= '0;
          curOdd <= fieldOdd;
        end
        S_WAIT: if (loadNow) begin
          state  <= S_SEND;
          acc    <= '0;
          bitIdx <= '0;
        end else begin
          dlyCnt <= dlyCnt + 1'b1;
        end
        S_SEND: begin
          acc <= accSum[PHASE_W-1:0];
          if (carry) begin
            if (lastBit) state <= S_IDLE;
            else         bitIdx <= bitIdx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Pending and status per field; a write takes priority over load/done
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendOdd <= 1'b0; pendEven <= 1'b0;
      statusOdd <= 1'b0; statusEven <= 1'b0;
    end else begin
      if (wrOdd) begin
        pendOdd   <= 1'b1;
        statusOdd <= 1'b0;
      end else begin
        if (loadNow && curOdd) pendOdd   <= 1'b0;
        if (doneNow && curOdd) statusOdd <= 1'b1;
      end
      if (wrEven) begin
        pendEven   <= 1'b1;
        statusEven <= 1'b0;
      end else begin
        if (loadNow && !curOdd) pendEven   <= 1'b0;
        if (doneNow && !curOdd) statusEven <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.load     = loadNow;
    strb.useNull  = curOdd ? !pendOdd : !pendEven;
    strb.fieldOdd = curOdd;
    strb.shift    = (state == S_SEND) && carry && !lastBit && (bitIdx >= IDX_W'(RUNIN_BITS));
    strb.sending  = (state == S_SEND);
    strb.runIn    = (bitIdx < IDX_W'(RUNIN_BITS));
    strb.runHigh  = !acc[PHASE_W-1];
    strb.lineOn   = lineOn;
  end

  // R3: a disabled field never claims the line
  a_r3_off_no_claim: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && ccEnable == 2'b00) |=> !lineOn);
  // R8: writing the odd pair clears its flag on the next clock
  a_r8_odd_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrOdd |=> !statusOdd);
  a_r8_even_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEven |=> !statusEven);
  // R8: a flag only rises at the end of a frame
  a_r8_odd_set_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOdd) |-> $past(state == S_SEND));
  // R9: the bit index only moves on an accumulator wrap
  a_r9_idx_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SEND && !carry) |=> $stable(bitIdx));
endmodule

// File: rtl/ccData.sv
module ccData
  import ccPkg::*;
#(
  parameter int          FRAME_BITS = 26,
  parameter int          RUNIN_BITS = 7,
  parameter int          LEVEL_W    = 8,
  parameter logic [7:0]  BLANK_LVL  = 8'd64,
  parameter logic [7:0]  HIGH_LVL   = 8'd176
) (
  input  logic               clk,
  input  logic               rstN,
  input  ccStrobes_t         strb,
  input  logic               wrOdd,
  input  logic               wrEven,
  input  logic [7:0]         wrByte0,
  input  logic [7:0]         wrByte1,
  output logic               ccOverride,
  output logic [LEVEL_W-1:0] ccLevel
);
  localparam int SR_W   = FRAME_BITS - RUNIN_BITS;
  localparam int NBYTES = 2;

  logic [7:0]      oddStore  [NBYTES];
  logic [7:0]      evenStore [NBYTES];
  logic [7:0]      frameByte [NBYTES];
  logic [SR_W-1:0] sr;
  logic            bitVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oddStore[0] <= '0; oddStore[1] <= '0;
      evenStore[0] <= '0; evenStore[1] <= '0;
    end else begin
      if (wrOdd)  begin oddStore[0]  <= wrByte0; oddStore[1]  <= wrByte1; end
      if (wrEven) begin evenStore[0] <= wrByte0; evenStore[1] <= wrByte1; end
    end
  end

  // Per-byte framing: 7 data bits, odd parity on top
  for (genvar g = 0; g < NBYTES; g++) begin : gByte
    logic [6:0] dataBits;
    assign dataBits     = strb.fieldOdd ? oddStore[g][6:0] : evenStore[g][6:0];
    assign frameByte[g] = strb.useNull ? 8'h80 : {~^dataBits, dataBits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) sr <= '0;
    else if (strb.load)  sr <= SR_W'({frameByte[1], frameByte[0], 3'b100});
    else if (strb.shift) sr <= sr >> 1;
  end

  always_comb bitVal = strb.runIn ? strb.runHigh : sr[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccOverride <= 1'b0;
      ccLevel    <= LEVEL_W'(BLANK_LVL);
    end else begin
      ccOverride <= strb.lineOn;
      ccLevel    <= (strb.sending && bitVal) ? LEVEL_W'(HIGH_LVL) : LEVEL_W'(BLANK_LVL);
    end
  end

  // R5: each frame starts from the start pattern in the low bits
  a_r5_start_loaded: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load) |-> (sr[2:0] == 3'b100));
endmodule

// File: rtl/ccLineSerializer.sv
module ccLineSerializer
  import ccPkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int SET_W     = 5,
  parameter int LEVEL_W   = 8,
  parameter int PHASE_W   = 16,
  parameter int PHASE_INC = 1221,
  parameter int START_DLY = 270
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStart,
  input  logic [LINE_W-1:0]  lineNum,
  input  logic               fieldOdd,
  input  logic               palMode,
  input  logic [1:0]         ccEnable,
  input  logic [SET_W-1:0]   ccLine,
  input  logic               wrOdd,
  input  logic               wrEven,
  input  logic [7:0]         wrByte0,
  input  logic [7:0]         wrByte1,
  output logic               ccOverride,
  output logic [LEVEL_W-1:0] ccLevel,
  output logic               statusOdd,
  output logic               statusEven
);
  localparam int FRAME_BITS = 26;
  localparam int RUNIN_BITS = 7;
  localparam logic [7:0] BLANK_LVL = 8'd64;
  localparam logic [7:0] HIGH_LVL  = 8'd176;

  ccStrobes_t strb;

  ccCtrl #(
    .LINE_W(LINE_W), .SET_W(SET_W), .NTSC_OFS(4), .PAL_OFS(1),
    .PHASE_W(PHASE_W), .PHASE_INC(PHASE_INC), .START_DLY(START_DLY),
    .FRAME_BITS(FRAME_BITS), .RUNIN_BITS(RUNIN_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .lineNum(lineNum),
    .fieldOdd(fieldOdd), .palMode(palMode), .ccEnable(ccEnable), .ccLine(ccLine),
    .wrOdd(wrOdd), .wrEven(wrEven), .strb(strb),
    .statusOdd(statusOdd), .statusEven(statusEven)
  );

  ccData #(
    .FRAME_BITS(FRAME_BITS), .RUNIN_BITS(RUNIN_BITS), .LEVEL_W(LEVEL_W),
    .BLANK_LVL(BLANK_LVL), .HIGH_LVL(HIGH_LVL)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrOdd(wrOdd), .wrEven(wrEven),
    .wrByte0(wrByte0), .wrByte1(wrByte1),
    .ccOverride(ccOverride), .ccLevel(ccLevel)
  );

  // R10: off the insertion line the level is always blank
  a_r10_blank_off_line: assert property (@(posedge clk) disable iff (!rstN)
    !ccOverride |-> (ccLevel == LEVEL_W'(BLANK_LVL)));
endmodule

// File: tb/tb_ccLineSerializer.sv
`timescale 1ns/1ps
module tb_ccLineSerializer;
  localparam int    D     = 270;
  localparam real   BITC  = 65536.0 / 1221.0;
  localparam logic [7:0] BLK = 8'd64;
  localparam logic [7:0] HI  = 8'd176;

  logic clk = 0, rstN = 0, lineStart = 0, fieldOdd = 0, palMode = 0;
  logic [9:0] lineNum = 0;
  logic [1:0] ccEnable = 0;
  logic [4:0] ccLine = 5'h11;
  logic wrOdd = 0, wrEven = 0;
  logic [7:0] wrByte0 = 0, wrByte1 = 0;
  logic ccOverride, statusOdd, statusEven;
  logic [7:0] ccLevel;

  int nChk = 0, nFail = 0, edgeCnt = 0, t0 = 0;
  bit finished = 0;

  ccLineSerializer dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitTo(input int m);
    while (edgeCnt < t0 + m) @(negedge clk);
  endtask

  task automatic startLine(input int ln, input bit odd);
    @(negedge clk);
    lineNum = 10'(ln); fieldOdd = odd; lineStart = 1;
    @(posedge clk);
    @(negedge clk);
    t0 = edgeCnt;
    lineStart = 0;
  endtask

  task automatic writePair(input bit odd, input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    wrByte0 = b0; wrByte1 = b1;
    if (odd) wrOdd = 1; else wrEven = 1;
    @(negedge clk);
    wrOdd = 0; wrEven = 0;
  endtask

  function automatic bit parBit(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 7; i++) ones += b[i];
    return (ones % 2 == 0);
  endfunction

  // A line that must stay untouched
  task automatic quietLine(input int ln, input bit odd, input string req);
    startLine(ln, odd);
    waitTo(500);
    check(req, ccOverride, 0);
    waitTo(1716);
  endtask

  // A full caption line with expected bytes
  task automatic frameLine(input int ln, input bit odd, input logic [7:0] b0,
                           input logic [7:0] b1, input string tag);
    bit exp [26];
    for (int k = 0; k < 7; k++) exp[k] = 0;
    exp[7] = 0; exp[8] = 0; exp[9] = 1;
    for (int i = 0; i < 7; i++) begin exp[10+i] = b0[i]; exp[18+i] = b1[i]; end
    exp[17] = parBit(b0); exp[25] = parBit(b1);
    startLine(ln, odd);
    waitTo(100);
    check({"R10 override ", tag}, ccOverride, 1);
    check({"R10 pre-frame blank ", tag}, ccLevel, BLK);
    for (int k = 0; k < 7; k++) begin
      waitTo(D + 2 + int'((k + 0.25) * BITC));
      check({"R4 run-in high ", tag}, ccLevel, HI);
      waitTo(D + 2 + int'((k + 0.75) * BITC));
      check({"R4 run-in low ", tag}, ccLevel, BLK);
    end
    for (int k = 7; k < 26; k++) begin
      waitTo(D + 2 + int'((k + 0.5) * BITC));
      check(k < 10 ? {"R5 start bit ", tag} : {"R6 R9 data bit ", tag},
            ccLevel, exp[k] ? HI : BLK);
    end
    waitTo(1700);
    check({"R10 post-frame blank ", tag}, ccLevel, BLK);
    check({"R10 override held ", tag}, ccOverride, 1);
    check({"R8 status set ", tag}, odd ? statusOdd : statusEven, 1);
    waitTo(1716);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 override", ccOverride, 0);
    check("R1 level", ccLevel, BLK);
    check("R1 statusOdd", statusOdd, 0);
    check("R1 statusEven", statusEven, 0);
    rstN = 1;
  endtask

  task automatic testNtscOdd();
    palMode = 0; ccEnable = 2'b01; ccLine = 5'h11;
    writePair(1, 8'h41, 8'hC2);               // R6: bit 7 ignored
    check("R8 flag low after write", statusOdd, 0);
    quietLine(20, 1, "R2 line before target");
    frameLine(21, 1, 8'h41, 8'h42, "ntsc odd");
    quietLine(21, 0, "R3 even disabled");
    frameLine(21, 1, 8'h00, 8'h00, "R7 null resend");
  endtask

  task automatic testStatusClear();
    writePair(1, 8'h55, 8'h2A);
    check("R8 odd cleared by write", statusOdd, 0);
  endtask

  task automatic testPalEven();
    palMode = 1; ccEnable = 2'b10; ccLine = 5'd5;
    writePair(0, 8'h00, 8'h7F);
    quietLine(6, 1, "R3 odd disabled");
    quietLine(9, 0, "R2 ntsc offset unused in pal");
    frameLine(6, 0, 8'h00, 8'h7F, "R2 pal even");
    check("R8 odd still clear", statusOdd, 0);
  endtask

  task automatic testBothAndOff();
    ccEnable = 2'b11;
    frameLine(6, 1, 8'h55, 8'h2A, "both odd");
    frameLine(6, 0, 8'h00, 8'h00, "R7 null even");
    ccEnable = 2'b00;
    quietLine(6, 1, "R3 off odd");
    quietLine(6, 0, "R3 off even");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    testReset();
    testNtscOdd();
    testStatusClear();
    testPalEven();
    testBothAndOff();
    finished = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule